// File: doc/BRIEF.md
# Register Rename Map Table

This block turns the architectural register names of a stream of instructions into temporary register tags, one instruction per clock. Each instruction may name up to two source registers and one destination register. A source is translated by reading a map table indexed by architectural register. Each map entry holds the tag of the most recent instruction that wrote that register, so a consumer is always pointed at its real producer. This holds even when the same loop body is issued over and over with the same register names.

A destination takes the next temporary from a pool of tags handed out in rising order. After reset the first tag handed out is T9, and tags T0..T8 stand for the initial contents of the architectural registers. The map entry of the destination is then overwritten with the new tag. When the pool is used up, an instruction that needs a destination is held back with a stall signal. Instructions without a destination, such as stores and branches, still pass. Release of tags and recovery after a wrong branch prediction belong to other blocks.

Top module: `rename_map_top`

## Requirements
- R1: After reset every map entry i maps to tag i, the next tag to hand out is FIRST_FREE (9), `pool_empty` is 0 and `out_valid` is 0.
- R2: An enabled source is replaced by the map tag of the latest accepted writer of that architectural register. A disabled source yields `out_srcN_en` = 0 and tag 0. Source indices must be below ARCH_REGS.
- R3: Each accepted instruction with a destination receives the next tag in sequence. The first is FIRST_FREE, and each later one is one above the previous. The map entry of that destination then holds the new tag.
- R4: Sources are looked up in the map as it stood before the same instruction's destination update. An instruction reading and writing register r therefore sees the older tag of r.
- R5: An accepted instruction without a destination gives `out_dst_en` = 0 and tag 0. It consumes no tag and leaves the map unchanged.
- R6: `pool_empty` rises in the cycle after the last tag (NUM_PHYS-1 = 63) is handed out, and it stays high until reset.
- R7: `stall` is high in the same cycle whenever `in_valid`, `in_dst_en` and `pool_empty` are all 1. A stalled instruction produces no output and changes neither the map nor the pool.
- R8: Results of an accepted instruction appear on the outputs exactly one clock after acceptance, with `out_valid` = 1.
- R9: A cycle with `in_valid` = 0 gives `out_valid` = 0 in the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_src0_en | input | 1 | First source used |
| in_src0 | input | 4 | First source architectural index |
| in_src1_en | input | 1 | Second source used |
| in_src1 | input | 4 | Second source architectural index |
| in_dst_en | input | 1 | Destination written |
| in_dst | input | 4 | Destination architectural index |
| stall | output | 1 | Instruction held back: no free tag |
| out_valid | output | 1 | Renamed instruction present |
| out_src0_en | output | 1 | First source used |
| out_src0_tag | output | 6 | First source tag |
| out_src1_en | output | 1 | Second source used |
| out_src1_tag | output | 6 | Second source tag |
| out_dst_en | output | 1 | Destination allocated |
| out_dst_tag | output | 6 | Destination tag |
| pool_empty | output | 1 | No tag left to hand out |

## Verification
The bench builds the block with its defaults: nine architectural registers, a 64-tag pool and allocation starting at T9. With these values the whole pool of 55 allocatable tags runs dry within a few dozen instructions. Exhaustion, the stall that follows and the passage of destination-free instructions during exhaustion can therefore all be driven in a short run. Every architectural index is swept as source and destination with in-place writes mixed in. The bench keeps its own arithmetic model of the map and of the next tag.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int unsigned RN_ARCH_REGS  = 9;
    parameter int unsigned RN_PHYS_REGS  = 64;
    parameter int unsigned RN_FIRST_FREE = 9;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int unsigned ARCH_REGS = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned AW = $clog2(ARCH_REGS),
    localparam int unsigned TW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd0_idx,
    output logic [TW-1:0] rd0_tag,
    input  logic [AW-1:0] rd1_idx,
    output logic [TW-1:0] rd1_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag
);
    logic [TW-1:0] map_q [ARCH_REGS];
    logic [TW-1:0] map_d [ARCH_REGS];

    // Reads see the table before this cycle's write.
    assign rd0_tag = map_q[rd0_idx];
    assign rd1_tag = map_q[rd1_idx];

    always_comb begin
        for (int i = 0; i < ARCH_REGS; i++) begin
            map_d[i] = map_q[i];
        end
        if (wr_en) begin
            map_d[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                map_q[i] <= TW'(i);
            end
        end else begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                map_q[i] <= map_d[i];
            end
        end
    end

    // R3
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (map_q[$past(wr_idx)] == $past(wr_tag)));

    // R2
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < ARCH_REGS));
endmodule

// File: rtl/rn_free_alloc.sv
module rn_free_alloc #(
    parameter int unsigned PHYS_REGS  = rn_pkg::RN_PHYS_REGS,
    parameter int unsigned FIRST_FREE = rn_pkg::RN_FIRST_FREE,
    localparam int unsigned TW = $clog2(PHYS_REGS),
    localparam int unsigned NW = $clog2(PHYS_REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    output logic [TW-1:0] tag,
    output logic          empty
);
    typedef struct packed {
        logic [NW-1:0] next;
    } alloc_st_t;

    alloc_st_t st_q, st_d;

    assign empty = (st_q.next == NW'(PHYS_REGS));
    assign tag   = st_q.next[TW-1:0];

    always_comb begin
        st_d = st_q;
        if (take && !empty) begin
            st_d.next = st_q.next + NW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.next <= NW'(FIRST_FREE);
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !empty) |=> (st_q.next == $past(st_q.next) + NW'(1)));

    // R5
    alloc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q.next));

    // R6
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> empty);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && empty));
endmodule

// File: rtl/rename_map_top.sv
module rename_map_top #(
    parameter int unsigned ARCH_REGS  = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned PHYS_REGS  = rn_pkg::RN_PHYS_REGS,
    parameter int unsigned FIRST_FREE = rn_pkg::RN_FIRST_FREE,
    localparam int unsigned AW = $clog2(ARCH_REGS),
    localparam int unsigned TW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_src0_en,
    input  logic [AW-1:0] in_src0,
    input  logic          in_src1_en,
    input  logic [AW-1:0] in_src1,
    input  logic          in_dst_en,
    input  logic [AW-1:0] in_dst,
    output logic          stall,
    output logic          out_valid,
    output logic          out_src0_en,
    output logic [TW-1:0] out_src0_tag,
    output logic          out_src1_en,
    output logic [TW-1:0] out_src1_tag,
    output logic          out_dst_en,
    output logic [TW-1:0] out_dst_tag,
    output logic          pool_empty
);
    typedef struct packed {
        logic          valid;
        logic          s0_en;
        logic [TW-1:0] s0_tag;
        logic          s1_en;
        logic [TW-1:0] s1_tag;
        logic          d_en;
        logic [TW-1:0] d_tag;
    } out_st_t;

    out_st_t       o_q, o_d;
    logic          accept;
    logic          take;
    logic [TW-1:0] rd0_tag, rd1_tag, new_tag;

    rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) map_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd0_idx(in_src0),
        .rd0_tag(rd0_tag),
        .rd1_idx(in_src1),
        .rd1_tag(rd1_tag),
        .wr_en  (take),
        .wr_idx (in_dst),
        .wr_tag (new_tag)
    );

    rn_free_alloc #(.PHYS_REGS(PHYS_REGS), .FIRST_FREE(FIRST_FREE)) alloc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .take (take),
        .tag  (new_tag),
        .empty(pool_empty)
    );

    assign stall  = in_valid && in_dst_en && pool_empty;
    assign accept = in_valid && !stall;
    assign take   = accept && in_dst_en;

    always_comb begin
        o_d        = '0;
        o_d.valid  = accept;
        o_d.s0_en  = accept && in_src0_en;
        o_d.s0_tag = (accept && in_src0_en) ? rd0_tag : '0;
        o_d.s1_en  = accept && in_src1_en;
        o_d.s1_tag = (accept && in_src1_en) ? rd1_tag : '0;
        o_d.d_en   = take;
        o_d.d_tag  = take ? new_tag : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid    = o_q.valid;
    assign out_src0_en  = o_q.s0_en;
    assign out_src0_tag = o_q.s0_tag;
    assign out_src1_en  = o_q.s1_en;
    assign out_src1_tag = o_q.s1_tag;
    assign out_dst_en   = o_q.d_en;
    assign out_dst_tag  = o_q.d_tag;

    // R7
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !out_valid);

    // R8
    accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall) |=> out_valid);

    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    nodst_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dst_en) |=> !out_dst_en);

    // R2
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src0_en) |-> (32'(in_src0) < ARCH_REGS));

    // R3
    dst_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dst_en |-> (32'(out_dst_tag) >= FIRST_FREE));
endmodule

// File: tb/rename_map_top_tb_top.sv
module rename_map_top_tb_top;
    localparam int AW = 4;
    localparam int TW = 6;
    localparam int NA = 9;
    localparam int NP = 64;
    localparam int FF = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_src0_en = 0, in_src1_en = 0, in_dst_en = 0;
    logic [AW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
    logic stall, out_valid, out_src0_en, out_src1_en, out_dst_en, pool_empty;
    logic [TW-1:0] out_src0_tag, out_src1_tag, out_dst_tag;

    int n_run = 0;
    int n_fail = 0;
    int mdl_map [NA];
    int mdl_next;
    bit done = 0;

    always #2 clk = ~clk;

    rename_map_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_src0_en(in_src0_en), .in_src0(in_src0),
        .in_src1_en(in_src1_en), .in_src1(in_src1),
        .in_dst_en(in_dst_en), .in_dst(in_dst),
        .stall(stall), .out_valid(out_valid),
        .out_src0_en(out_src0_en), .out_src0_tag(out_src0_tag),
        .out_src1_en(out_src1_en), .out_src1_tag(out_src1_tag),
        .out_dst_en(out_dst_en), .out_dst_tag(out_dst_tag),
        .pool_empty(pool_empty)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NA; i++) mdl_map[i] = i;
        mdl_next = FF;
    endtask

    task automatic issue(input bit v, input bit s0e, input int s0,
                         input bit s1e, input int s1, input bit de, input int d);
        bit exp_stall, acc;
        int e0, e1, ed;
        @(negedge clk);
        in_valid = v; in_src0_en = s0e; in_src0 = AW'(s0);
        in_src1_en = s1e; in_src1 = AW'(s1); in_dst_en = de; in_dst = AW'(d);
        #1;
        exp_stall = v && de && (mdl_next == NP);
        check("R7 stall", int'(stall), int'(exp_stall));
        acc = v && !exp_stall;
        // R4: expected sources taken before the model update
        e0 = (acc && s0e) ? mdl_map[s0] : 0;
        e1 = (acc && s1e) ? mdl_map[s1] : 0;
        ed = (acc && de) ? mdl_next : 0;
        if (acc && de) begin
            mdl_map[d] = mdl_next;
            mdl_next++;
        end
        @(posedge clk);
        #1;
        check("R8/R9 out_valid", int'(out_valid), int'(acc));
        check("R2 src0_en", int'(out_src0_en), int'(acc && s0e));
        check("R2/R4 src0_tag", int'(out_src0_tag), e0);
        check("R2 src1_en", int'(out_src1_en), int'(acc && s1e));
        check("R2/R4 src1_tag", int'(out_src1_tag), e1);
        check("R5 dst_en", int'(out_dst_en), int'(acc && de));
        check("R3 dst_tag", int'(out_dst_tag), ed);
        check("R6 pool_empty", int'(pool_empty), int'(mdl_next == NP));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_src0_en = 0; in_src1_en = 0; in_dst_en = 0;
        @(posedge clk); @(posedge clk);
        #1;
        model_reset();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 pool_empty", int'(pool_empty), 0);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic identity_sweep();
        // R1: every entry maps to itself after reset
        for (int i = 0; i < NA; i++) issue(1, 1, i, 1, (i + 1) % NA, 0, 0);
    endtask

    initial begin
        model_reset();
        do_reset();
        identity_sweep();
        // R3: first allocation is T9
        issue(1, 0, 0, 0, 0, 1, 2);
        // R4: in-place write reads older tag
        issue(1, 1, 2, 1, 2, 1, 2);
        issue(1, 1, 2, 0, 0, 1, 5);
        // R9: idle cycle
        issue(0, 1, 1, 1, 1, 1, 1);
        // mixed sweep over all indices
        for (int k = 0; k < 36; k++)
            issue(1, (k % 3) != 2, k % NA, (k % 5) != 4, (k * 5 + 3) % NA,
                  (k % 4) != 3, (k * 7 + 1) % NA);
        // R6: drain the pool
        while (mdl_next < NP) issue(1, 1, mdl_next % NA, 0, 0, 1, mdl_next % NA);
        // R7: stalled instruction must leave map unchanged
        issue(1, 1, 4, 0, 0, 1, 4);
        issue(1, 1, 4, 1, 7, 1, 7);
        // R5: no-destination instructions still pass when empty
        issue(1, 1, 4, 1, 7, 0, 0);
        issue(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < NA; i++) issue(1, 1, i, 0, 0, 0, 0);
        // R1: second reset restores identity and T9
        do_reset();
        identity_sweep();
        issue(1, 1, 3, 0, 0, 1, 3);
        issue(1, 1, 3, 0, 0, 0, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule